// File: doc/BRIEF.md
# Alarm Real-Time Clock with Register Interface

This block keeps a 64-bit time value counted in nanoseconds. The value rises by a fixed step on every clock cycle. A 64-bit alarm register can be armed against it. When the alarm time is reached, the block sets an interrupt-pending flag. The interrupt line is that flag qualified by a software enable bit.

Software uses a simple 32-bit register port with single-cycle requests. It can read the live time as two 32-bit halves, and it can overwrite either half while the count keeps running. Alarm writes are split: the upper word is written first, and writing the lower word arms the alarm with the full 64-bit value. A status register reports whether an armed alarm is still waiting. Two write-only locations cancel a waiting alarm and acknowledge the interrupt.

Top module: `mmio_alarm_clock`

## Requirements
- R1: After reset the time count is zero. It rises by STEP_NS on every cycle in which it is not written. A read of offset 0x00 returns bits 31:0 and a read of offset 0x04 returns bits 63:32 of the count as it stood in the request cycle, with carries crossing the halves.
- R2: A write to 0x00 or 0x04 replaces only that 32-bit half of the count and keeps the other half. Counting continues from the new value, so a read issued in the next cycle returns exactly the written word.
- R3: A write to 0x0C stores only the upper alarm word and does not arm the alarm. A write to 0x08 stores the lower word and arms the alarm with the full 64-bit value. Both words read back at their own offsets.
- R4: When the alarm is armed with a value less than or equal to the count in the arming cycle, the pending flag sets at once and the running flag stays clear.
- R5: When the alarm is armed with a later value, the running flag (bit 0 at 0x18) sets. In the first cycle where the count is greater than or equal to the alarm, the running flag clears and the pending flag sets.
- R6: A write to 0x10 stores only bit 0 of the data as the enable, and the enable reads back at 0x10. The interrupt output equals pending AND enable, and it follows an enable change in the cycle after the write.
- R7: A write to 0x14 clears the running flag. A cancelled alarm never raises pending, and cancel wins over a match in the same cycle.
- R8: A write to 0x1C clears the pending flag. A match in the same cycle wins, so the new event is not lost.
- R9: Reads of 0x14, 0x1C, any offset whose bits 1:0 are not zero, and any offset above 0x1C return zero. Writes to 0x18 and to unaligned or unmapped offsets change no state.
- R10: Reset clears the alarm value, the running flag, the pending flag, the enable and the interrupt output.
- R11: Read data is registered. It appears in the cycle after a read request and holds its value until the next read request, whatever writes occur in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request in this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte offset of the register |
| req_wdata_i | input | DATA_W | Write data |
| rsp_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt, pending AND enable |

## Verification
Every register effect lands on the clock edge that samples the request. A read therefore returns state one cycle after it is issued, and the interrupt line reflects a write or a match one edge later. The bench drives each request on a falling edge and samples read data and the interrupt on the following falling edge. Expected time values are counted in whole steps from the last time write. For a future alarm, the bench counts the edges from the arming write until the interrupt appears and compares that count with the exact value derived from the alarm distance divided by the step. Cancel, acknowledge and enable effects are observed on the interrupt pin or read back through the register port in the cycle right after the write.

// File: rtl/alarm_clock_pkg.sv
package alarm_clock_pkg;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned NSLOT  = 8;
    localparam int unsigned SEL_W  = $clog2(NSLOT);

    // register slot, indexed by address bits 4:2
    typedef enum logic [SEL_W-1:0] {
        SLOT_TIME_LO  = 3'd0,
        SLOT_TIME_HI  = 3'd1,
        SLOT_ALRM_LO  = 3'd2,
        SLOT_ALRM_HI  = 3'd3,
        SLOT_IRQ_EN   = 3'd4,
        SLOT_CANCEL   = 3'd5,
        SLOT_STATUS   = 3'd6,
        SLOT_ACK      = 3'd7
    } slot_e;

endpackage

// File: rtl/ac_reg_decode.sv
module ac_reg_decode
    import alarm_clock_pkg::*;
(
    input  logic              valid_i,
    input  logic              write_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NSLOT-1:0]  wr_hit_o,
    output logic              rd_hit_o,
    output slot_e             slot_o
);

    logic             aligned;
    logic [SEL_W-1:0] idx;

    assign aligned  = (addr_i[1:0] == 2'b00);
    assign idx      = addr_i[ADDR_W-1:2];
    assign slot_o   = slot_e'(idx);
    assign rd_hit_o = valid_i && !write_i && aligned;

    for (genvar i = 0; i < NSLOT; i++) begin : g_strobe
        assign wr_hit_o[i] = valid_i && write_i && aligned && (idx == SEL_W'(i));
    end

endmodule

// File: rtl/ac_time_counter.sv
module ac_time_counter #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned STEP_NS = 20,
    localparam int unsigned TIME_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [TIME_W-1:0] now_o
);

    typedef struct packed {
        logic [TIME_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.count = st_q.count + TIME_W'(STEP_NS);
        if (wr_lo_i) begin
            st_d.count = {st_q.count[TIME_W-1:DATA_W], wdata_i};
        end
        if (wr_hi_i) begin
            st_d.count = {wdata_i, st_q.count[DATA_W-1:0]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now_o = st_q.count;

endmodule

// File: rtl/ac_alarm_unit.sv
module ac_alarm_unit #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned TIME_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TIME_W-1:0] now_i,
    input  logic              wr_alo_i,
    input  logic              wr_ahi_i,
    input  logic              wr_ien_i,
    input  logic              wr_cancel_i,
    input  logic              wr_ack_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [TIME_W-1:0] alarm_o,
    output logic              running_o,
    output logic              pending_o,
    output logic              enable_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [TIME_W-1:0] alarm;
        logic              running;
        logic              pending;
        logic              enable;
    } alm_state_t;

    alm_state_t        st_d, st_q;
    logic [TIME_W-1:0] arm_val;
    logic              match;

    always_comb begin
        st_d    = st_q;
        arm_val = {st_q.alarm[TIME_W-1:DATA_W], wdata_i};
        match   = st_q.running && (now_i >= st_q.alarm) && !wr_cancel_i;

        // acknowledge first so a match in the same cycle survives
        if (wr_ack_i) begin
            st_d.pending = 1'b0;
        end
        if (match) begin
            st_d.running = 1'b0;
            st_d.pending = 1'b1;
        end
        if (wr_cancel_i) begin
            st_d.running = 1'b0;
        end
        if (wr_ahi_i) begin
            st_d.alarm[TIME_W-1:DATA_W] = wdata_i;
        end
        if (wr_alo_i) begin
            st_d.alarm[DATA_W-1:0] = wdata_i;
            if (arm_val <= now_i) begin
                st_d.running = 1'b0;
                st_d.pending = 1'b1;
            end else begin
                st_d.running = 1'b1;
            end
        end
        if (wr_ien_i) begin
            st_d.enable = wdata_i[0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_o   = st_q.alarm;
    assign running_o = st_q.running;
    assign pending_o = st_q.pending;
    assign enable_o  = st_q.enable;
    assign irq_o     = st_q.pending & st_q.enable;

endmodule

// File: rtl/mmio_alarm_clock.sv
module mmio_alarm_clock
    import alarm_clock_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned STEP_NS = 20
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [4:0]        req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              irq_o
);

    localparam int unsigned TIME_W = 2 * DATA_W;

    logic [NSLOT-1:0]  wr_hit;
    logic              rd_hit;
    slot_e             slot;
    logic [TIME_W-1:0] time_val;
    logic [TIME_W-1:0] alarm_val;
    logic              alarm_running;
    logic              irq_pending;
    logic              irq_enable;

    ac_reg_decode u_dec (
        .valid_i  (req_valid_i),
        .write_i  (req_write_i),
        .addr_i   (req_addr_i),
        .wr_hit_o (wr_hit),
        .rd_hit_o (rd_hit),
        .slot_o   (slot)
    );

    ac_time_counter #(
        .DATA_W  (DATA_W),
        .STEP_NS (STEP_NS)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_lo_i (wr_hit[SLOT_TIME_LO]),
        .wr_hi_i (wr_hit[SLOT_TIME_HI]),
        .wdata_i (req_wdata_i),
        .now_o   (time_val)
    );

    ac_alarm_unit #(
        .DATA_W (DATA_W)
    ) u_alm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .now_i       (time_val),
        .wr_alo_i    (wr_hit[SLOT_ALRM_LO]),
        .wr_ahi_i    (wr_hit[SLOT_ALRM_HI]),
        .wr_ien_i    (wr_hit[SLOT_IRQ_EN]),
        .wr_cancel_i (wr_hit[SLOT_CANCEL]),
        .wr_ack_i    (wr_hit[SLOT_ACK]),
        .wdata_i     (req_wdata_i),
        .alarm_o     (alarm_val),
        .running_o   (alarm_running),
        .pending_o   (irq_pending),
        .enable_o    (irq_enable),
        .irq_o       (irq_o)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rsp_state_t;

    rsp_state_t rsp_d, rsp_q;

    always_comb begin
        rsp_d = rsp_q;
        if (rd_hit) begin
            unique case (slot)
                SLOT_TIME_LO: rsp_d.rdata = time_val[DATA_W-1:0];
                SLOT_TIME_HI: rsp_d.rdata = time_val[TIME_W-1:DATA_W];
                SLOT_ALRM_LO: rsp_d.rdata = alarm_val[DATA_W-1:0];
                SLOT_ALRM_HI: rsp_d.rdata = alarm_val[TIME_W-1:DATA_W];
                SLOT_IRQ_EN:  rsp_d.rdata = DATA_W'(irq_enable);
                SLOT_STATUS:  rsp_d.rdata = DATA_W'(alarm_running);
                default:      rsp_d.rdata = '0;
            endcase
        end else if (req_valid_i && !req_write_i) begin
            rsp_d.rdata = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_rdata_o = rsp_q.rdata;

endmodule

// File: rtl/mmio_alarm_clock_chk.sv
module mmio_alarm_clock_chk #(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned STEP_NS = 20,
    localparam int unsigned TIME_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [4:0]        req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DATA_W-1:0] rsp_rdata_o,
    input  logic [TIME_W-1:0] time_val,
    input  logic [TIME_W-1:0] alarm_val,
    input  logic              alarm_running,
    input  logic              irq_pending,
    input  logic              irq_enable
);

    logic wr_any, w_tlo, w_thi, w_alo, w_ien, w_cancel;
    logic [TIME_W-1:0] arm_probe;

    assign wr_any    = req_valid_i && req_write_i;
    assign w_tlo     = wr_any && (req_addr_i == 5'h00);
    assign w_thi     = wr_any && (req_addr_i == 5'h04);
    assign w_alo     = wr_any && (req_addr_i == 5'h08);
    assign w_ien     = wr_any && (req_addr_i == 5'h10);
    assign w_cancel  = wr_any && (req_addr_i == 5'h14);
    assign arm_probe = {alarm_val[TIME_W-1:DATA_W], req_wdata_i};

    assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(w_tlo || w_thi) |=> time_val == $past(time_val) + TIME_W'(STEP_NS));

    assert_arm_past_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w_alo && (arm_probe <= time_val)) |=> (irq_pending && !alarm_running));

    assert_arm_future_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w_alo && (arm_probe > time_val)) |=> alarm_running);

    assert_match_fires_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (alarm_running && (time_val >= alarm_val) && !w_cancel && !w_alo)
        |=> (irq_pending && !alarm_running));

    assert_cancel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_cancel |=> !alarm_running);

    assert_enable_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        w_ien |=> (irq_enable == $past(req_wdata_i[0])));

    assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(req_valid_i && !req_write_i) |=> $stable(rsp_rdata_o));

endmodule

bind mmio_alarm_clock mmio_alarm_clock_chk #(
    .DATA_W  (DATA_W),
    .STEP_NS (STEP_NS)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .rsp_rdata_o   (rsp_rdata_o),
    .time_val      (time_val),
    .alarm_val     (alarm_val),
    .alarm_running (alarm_running),
    .irq_pending   (irq_pending),
    .irq_enable    (irq_enable)
);

// File: tb/sim_mmio_alarm_clock.sv
module sim_mmio_alarm_clock;

    localparam int unsigned DW   = 32;
    localparam int unsigned STEP = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [4:0]    req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    mmio_alarm_clock #(.DATA_W(DW), .STEP_NS(STEP)) u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rsp_rdata_o (rsp_rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 5'h04, 32'h0000_0002, 32'h0,         4'd2},  // R2 high half
        '{1'b1, 5'h00, 32'hFFFF_FFF0, 32'h0,         4'd2},  // R2 low half
        '{1'b0, 5'h00, 32'h0,         32'hFFFF_FFF0, 4'd2},  // R2 exact readback
        '{1'b0, 5'h04, 32'h0,         32'h0000_0003, 4'd1},  // R1 carry into high
        '{1'b0, 5'h00, 32'h0,         32'h0000_0018, 4'd1},  // R1 step
        '{1'b1, 5'h10, 32'hFFFF_FFFE, 32'h0,         4'd6},  // R6 bit0 only
        '{1'b0, 5'h10, 32'h0,         32'h0,         4'd6},
        '{1'b1, 5'h10, 32'h0000_0003, 32'h0,         4'd6},
        '{1'b0, 5'h10, 32'h0,         32'h1,         4'd6},
        '{1'b0, 5'h14, 32'h0,         32'h0,         4'd9},  // R9 write-only
        '{1'b0, 5'h1C, 32'h0,         32'h0,         4'd9},
        '{1'b1, 5'h11, 32'h0,         32'h0,         4'd9},  // R9 unaligned write
        '{1'b0, 5'h10, 32'h0,         32'h1,         4'd9},
        '{1'b1, 5'h18, 32'hFFFF_FFFF, 32'h0,         4'd9},  // R9 read-only
        '{1'b0, 5'h18, 32'h0,         32'h0,         4'd9},
        '{1'b0, 5'h0C, 32'h0,         32'h0,         4'd10}, // R10 alarm cleared
        '{1'b1, 5'h0C, 32'h0000_0007, 32'h0,         4'd3},  // R3 high only
        '{1'b0, 5'h0C, 32'h0,         32'h7,         4'd3},
        '{1'b0, 5'h08, 32'h0,         32'h0,         4'd3},
        '{1'b0, 5'h18, 32'h0,         32'h0,         4'd3},  // R3 not armed
        '{1'b0, 5'h05, 32'h0,         32'h0,         4'd9},  // R9 unaligned read
        '{1'b1, 5'h0C, 32'h0,         32'h0,         4'd3}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, 64'(rsp_rdata), 64'(e));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 irq in reset", 64'(irq), 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        // reset state: R1 count starts at zero, R10 registers cleared
        bus_rd(5'h00, 32'h0, "R1 time low after reset");
        bus_rd(5'h04, 32'h0, "R1 time high after reset");
        bus_rd(5'h08, 32'h0, "R10 alarm low");
        bus_rd(5'h10, 32'h0, "R10 enable");
        bus_rd(5'h18, 32'h0, "R10 running");
        chk("R10 irq", 64'(irq), 64'd0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].wr) begin
                bus_wr(TBL[i].addr, TBL[i].data);
            end else begin
                bus_rd(TBL[i].addr, TBL[i].exp,
                       $sformatf("R%0d vector %0d", TBL[i].req, i));
            end
        end

        // R5: future alarm, exact number of edges until interrupt
        bus_wr(5'h04, 32'h0);
        bus_wr(5'h00, 32'd1000);
        bus_wr(5'h08, 32'd1200);
        begin
            int n = 0;
            while (!irq && n < 40) begin
                @(negedge clk);
                n++;
            end
            chk("R5 edges from arm to irq", 64'(n), 64'd10);
        end
        bus_rd(5'h18, 32'h0, "R5 running cleared on match");
        bus_rd(5'h08, 32'd1200, "R3 alarm low readback");

        // R6: enable gates the pending flag
        bus_wr(5'h10, 32'h0);
        chk("R6 irq masked", 64'(irq), 64'd0);
        bus_wr(5'h10, 32'h1);
        chk("R6 irq unmasked", 64'(irq), 64'd1);

        // R8: acknowledge clears pending, enable kept
        bus_wr(5'h1C, 32'h0);
        chk("R8 irq after ack", 64'(irq), 64'd0);
        bus_rd(5'h10, 32'h1, "R8 enable kept");

        // R4: alarm in the past fires at once
        bus_wr(5'h08, 32'h0);
        chk("R4 past alarm irq", 64'(irq), 64'd1);
        bus_rd(5'h18, 32'h0, "R4 not running");
        bus_wr(5'h1C, 32'h0);

        // R4: alarm equal to current count fires at once
        bus_wr(5'h00, 32'd5000);
        bus_wr(5'h08, 32'd5000);
        chk("R4 equal alarm irq", 64'(irq), 64'd1);
        bus_rd(5'h18, 32'h0, "R4 equal not running");
        bus_wr(5'h1C, 32'h0);
        chk("R8 cleared", 64'(irq), 64'd0);

        // R5: one above current count arms, then matches on next edge
        bus_wr(5'h00, 32'd5000);
        bus_wr(5'h08, 32'd5001);
        bus_rd(5'h18, 32'h1, "R5 armed running");
        chk("R5 fired after one step", 64'(irq), 64'd1);
        bus_wr(5'h1C, 32'h0);

        // R7: cancel prevents the interrupt
        bus_wr(5'h00, 32'h0);
        bus_wr(5'h08, 32'd100000);
        bus_rd(5'h18, 32'h1, "R7 running before cancel");
        bus_wr(5'h14, 32'h0);
        bus_rd(5'h18, 32'h0, "R7 running after cancel");
        repeat (5200) @(negedge clk);
        chk("R7 no irq after cancel", 64'(irq), 64'd0);

        // R11: read data holds across idle cycles and writes
        bus_rd(5'h10, 32'h1, "R11 read");
        repeat (3) @(negedge clk);
        bus_wr(5'h0C, 32'h9);
        chk("R11 rdata held", 64'(rsp_rdata), 64'd1);

        // R10: reset with a live interrupt
        bus_wr(5'h0C, 32'h0);
        bus_wr(5'h08, 32'h0);
        chk("R10 irq before reset", 64'(irq), 64'd1);
        do_reset();
        bus_rd(5'h00, 32'h0, "R1 count zero after reset");
        bus_rd(5'h10, 32'h0, "R10 enable after reset");
        bus_rd(5'h0C, 32'h0, "R10 alarm high after reset");
        bus_rd(5'h18, 32'h0, "R10 running after reset");
        chk("R10 irq after reset", 64'(irq), 64'd0);

        finish_run();
    end

endmodule